// File: doc/BRIEF.md
# Adaptive Pen Sample-Rate Scheduler

This block decides when a pen digitizer takes its next coordinate sample. A slow timebase tick (nominally 1 kHz) drives a period counter. While the pen touches the surface, the counter raises a one-cycle sample request once per period. The period is short (fast rate, about 83 samples per second) when the last accepted pen position falls inside one of up to four software-programmed precision rectangles. It is long (slow rate, 10 samples per second) when that position is outside all of them. Software may rewrite the rectangles at any time.

The converter front end returns each sample with coordinates and a validity flag. Samples that the front end has flagged bad, for example because two contacts touched the surface at once, are dropped silently. Only good samples are passed on with an accept strobe, and only good samples take part in the rate decision. Each accepted sample re-evaluates the rate. A new rate is adopted only when the running period ends, so a period is never cut short or stretched. Lifting the pen stops all requests, clears the period and returns the block to the fast rate, so the first sample after the pen touches down comes after one fast period.

Top module: `pen_rate_sched`

## Requirements
- R1: After reset, no sample request and no accept strobe are raised, and the rate status reads fast (`fast_o` = 1).
- R2: While `pen_down_i` is 0, no sample request is issued, the period count is cleared, and `fast_o` returns to 1 one cycle after the pen lifts.
- R3: At the fast rate, `req_o` rises once every 12 ticks, counted from the previous request or from pen-down.
- R4: At the slow rate, `req_o` rises once every 100 ticks.
- R5: The first request after the pen touches down comes on the 12th tick, whatever rate was in use before the pen lifted.
- R6: A region matches when its enable bit is 1 and xlo <= x <= xhi and ylo <= y <= yhi, with both bounds inclusive. Region i occupies bits [10*i+9:10*i] of each bound bus and bit i of `rgn_en_i`. An accepted sample that matches any region selects the fast rate; otherwise it selects the slow rate.
- R7: A region whose enable bit is 0 never matches, even when its bounds cover the sample.
- R8: A sample presented with `smp_ok_i` = 0 produces no accept strobe and does not change the rate decision.
- R9: A sample presented with `smp_stb_i` = 1 and `smp_ok_i` = 1 raises `acc_o` for one cycle on the next clock. During that cycle, `acc_x_o` and `acc_y_o` hold its coordinates.
- R10: A rate decision takes effect only at the end of the running period. The period in progress keeps its length, and `fast_o` changes in the same cycle as the request that closes it.
- R11: `req_o` is high for a single clock cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Timebase strobe, one cycle per tick |
| pen_down_i | input | 1 | Pen is touching the surface |
| smp_stb_i | input | 1 | A sample result is presented this cycle |
| smp_ok_i | input | 1 | Front end judged the sample valid |
| smp_x_i | input | 10 | Sample X coordinate |
| smp_y_i | input | 10 | Sample Y coordinate |
| rgn_en_i | input | 4 | Per-region enable |
| rgn_xlo_i | input | 40 | Per-region inclusive X lower bounds |
| rgn_xhi_i | input | 40 | Per-region inclusive X upper bounds |
| rgn_ylo_i | input | 40 | Per-region inclusive Y lower bounds |
| rgn_yhi_i | input | 40 | Per-region inclusive Y upper bounds |
| req_o | output | 1 | Sample request strobe |
| acc_o | output | 1 | Accepted coordinate strobe |
| acc_x_o | output | 10 | Accepted X coordinate |
| acc_y_o | output | 10 | Accepted Y coordinate |
| fast_o | output | 1 | Rate status, 1 for fast and 0 for slow |

## Verification
The assertions assume the following about the inputs:
- `tick_i` is a one-cycle strobe.
- The fast and slow period parameters are at least two ticks, so a request can never follow the previous one on the next clock.
- A sample strobe lasts a single cycle.

The stimulus keeps to these assumptions. Every tick and every sample is driven high for exactly one cycle, ticks and samples never share a cycle, and each sample is presented just after a request, at the start of a period. Region bounds are set before the pen goes down and are held steady while samples are compared against them.

// File: rtl/pen_rate_pkg.sv
package pen_rate_pkg;

    localparam int COORD_W = 10;

    typedef logic [COORD_W-1:0] coord_t;

    typedef struct packed {
        coord_t x;
        coord_t y;
    } point_t;

    typedef struct packed {
        logic   en;
        coord_t x_lo;
        coord_t x_hi;
        coord_t y_lo;
        coord_t y_hi;
    } region_t;

    typedef enum logic {
        RATE_SLOW = 1'b0,
        RATE_FAST = 1'b1
    } rate_e;

    // Inclusive rectangle containment, gated by the region enable.
    function automatic logic point_in(region_t r, point_t p);
        return r.en
            && (p.x >= r.x_lo) && (p.x <= r.x_hi)
            && (p.y >= r.y_lo) && (p.y <= r.y_hi);
    endfunction

endpackage

// File: rtl/pen_region_match.sv
module pen_region_match
    import pen_rate_pkg::*;
#(
    parameter int NUM_RGN = 4
) (
    input  region_t [NUM_RGN-1:0] rgn_i,
    input  point_t                pt_i,
    output logic                  hit_o
);

    logic [NUM_RGN-1:0] hit_vec;

    for (genvar i = 0; i < NUM_RGN; i++) begin : g_rgn
        assign hit_vec[i] = point_in(rgn_i[i], pt_i);
    end

    assign hit_o = |hit_vec;

endmodule

// File: rtl/pen_sample_gate.sv
module pen_sample_gate
    import pen_rate_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   pen_down_i,
    input  logic   smp_stb_i,
    input  logic   smp_ok_i,
    input  point_t smp_pt_i,
    input  logic   hit_i,
    output logic   acc_o,
    output point_t acc_pt_o,
    output rate_e  next_rate_o
);

    logic take;
    assign take = smp_stb_i && smp_ok_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_o       <= 1'b0;
            acc_pt_o    <= '0;
            next_rate_o <= RATE_FAST;
        end else begin
            acc_o <= take;
            if (take) begin
                acc_pt_o <= smp_pt_i;
            end
            if (!pen_down_i) begin
                next_rate_o <= RATE_FAST;
            end else if (take) begin
                next_rate_o <= hit_i ? RATE_FAST : RATE_SLOW;
            end
        end
    end

    // R8: a flagged-bad sample never yields an accept strobe
    a_r8_drop_invalid: assert property (@(posedge clk) disable iff (rst)
        (smp_stb_i && !smp_ok_i) |=> !acc_o);

    // R9: every accept strobe traces back to a good sample one cycle earlier
    a_r9_acc_source: assert property (@(posedge clk) disable iff (rst)
        acc_o |-> $past(smp_stb_i && smp_ok_i));

    // R8: the rate decision moves only after a good sample or a pen lift
    a_r8_decision_source: assert property (@(posedge clk) disable iff (rst)
        !$stable(next_rate_o) |-> ($past(smp_stb_i && smp_ok_i) || $past(!pen_down_i)));

endmodule

// File: rtl/pen_period_timer.sv
module pen_period_timer
    import pen_rate_pkg::*;
#(
    parameter int FAST_TICKS = 12,
    parameter int SLOW_TICKS = 100
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  tick_i,
    input  logic  pen_down_i,
    input  rate_e next_rate_i,
    output logic  req_o,
    output rate_e cur_rate_o
);

    localparam int MAX_TICKS = (FAST_TICKS > SLOW_TICKS) ? FAST_TICKS : SLOW_TICKS;
    localparam int CNT_W     = $clog2(MAX_TICKS + 1);
    localparam logic [CNT_W-1:0] FAST_LAST = CNT_W'(FAST_TICKS - 1);
    localparam logic [CNT_W-1:0] SLOW_LAST = CNT_W'(SLOW_TICKS - 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;

    assign last = (cur_rate_o == RATE_FAST) ? FAST_LAST : SLOW_LAST;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt        <= '0;
            req_o      <= 1'b0;
            cur_rate_o <= RATE_FAST;
        end else begin
            req_o <= 1'b0;
            if (!pen_down_i) begin
                cnt        <= '0;
                cur_rate_o <= RATE_FAST;
            end else if (tick_i) begin
                if (cnt >= last) begin
                    cnt        <= '0;
                    req_o      <= 1'b1;
                    cur_rate_o <= next_rate_i;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R2: no request follows a cycle with the pen lifted
    a_r2_quiet_pen_up: assert property (@(posedge clk) disable iff (rst)
        !pen_down_i |=> !req_o);

    // R2: lifting the pen restores the fast rate
    a_r2_pen_up_fast: assert property (@(posedge clk) disable iff (rst)
        !pen_down_i |=> (cur_rate_o == RATE_FAST));

    // R11: a request lasts exactly one cycle
    a_r11_req_pulse: assert property (@(posedge clk) disable iff (rst)
        req_o |=> !req_o);

    // R10: the rate changes only together with a period-closing request or after a pen lift
    a_r10_rate_at_boundary: assert property (@(posedge clk) disable iff (rst)
        !$stable(cur_rate_o) |-> (req_o || $past(!pen_down_i)));

    // R3: a request is only produced by a tick
    a_r3_req_from_tick: assert property (@(posedge clk) disable iff (rst)
        req_o |-> $past(tick_i && pen_down_i));

endmodule

// File: rtl/pen_rate_sched.sv
module pen_rate_sched
    import pen_rate_pkg::*;
#(
    parameter int NUM_RGN    = 4,
    parameter int FAST_TICKS = 12,
    parameter int SLOW_TICKS = 100
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       tick_i,
    input  logic                       pen_down_i,
    input  logic                       smp_stb_i,
    input  logic                       smp_ok_i,
    input  logic [COORD_W-1:0]         smp_x_i,
    input  logic [COORD_W-1:0]         smp_y_i,
    input  logic [NUM_RGN-1:0]         rgn_en_i,
    input  logic [NUM_RGN*COORD_W-1:0] rgn_xlo_i,
    input  logic [NUM_RGN*COORD_W-1:0] rgn_xhi_i,
    input  logic [NUM_RGN*COORD_W-1:0] rgn_ylo_i,
    input  logic [NUM_RGN*COORD_W-1:0] rgn_yhi_i,
    output logic                       req_o,
    output logic                       acc_o,
    output logic [COORD_W-1:0]         acc_x_o,
    output logic [COORD_W-1:0]         acc_y_o,
    output logic                       fast_o
);

    region_t [NUM_RGN-1:0] rgn;
    point_t                smp_pt;
    point_t                acc_pt;
    logic                  hit;
    rate_e                 next_rate;
    rate_e                 cur_rate;

    for (genvar i = 0; i < NUM_RGN; i++) begin : g_unpack
        assign rgn[i].en   = rgn_en_i[i];
        assign rgn[i].x_lo = rgn_xlo_i[i*COORD_W +: COORD_W];
        assign rgn[i].x_hi = rgn_xhi_i[i*COORD_W +: COORD_W];
        assign rgn[i].y_lo = rgn_ylo_i[i*COORD_W +: COORD_W];
        assign rgn[i].y_hi = rgn_yhi_i[i*COORD_W +: COORD_W];
    end

    assign smp_pt.x = smp_x_i;
    assign smp_pt.y = smp_y_i;

    pen_region_match #(
        .NUM_RGN (NUM_RGN)
    ) u_match (
        .rgn_i (rgn),
        .pt_i  (smp_pt),
        .hit_o (hit)
    );

    pen_sample_gate u_gate (
        .clk         (clk),
        .rst         (rst),
        .pen_down_i  (pen_down_i),
        .smp_stb_i   (smp_stb_i),
        .smp_ok_i    (smp_ok_i),
        .smp_pt_i    (smp_pt),
        .hit_i       (hit),
        .acc_o       (acc_o),
        .acc_pt_o    (acc_pt),
        .next_rate_o (next_rate)
    );

    pen_period_timer #(
        .FAST_TICKS (FAST_TICKS),
        .SLOW_TICKS (SLOW_TICKS)
    ) u_timer (
        .clk         (clk),
        .rst         (rst),
        .tick_i      (tick_i),
        .pen_down_i  (pen_down_i),
        .next_rate_i (next_rate),
        .req_o       (req_o),
        .cur_rate_o  (cur_rate)
    );

    assign acc_x_o = acc_pt.x;
    assign acc_y_o = acc_pt.y;
    assign fast_o  = (cur_rate == RATE_FAST);

    // R1: both strobes are low in the first cycle after reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> (!req_o && !acc_o && fast_o));

endmodule

// File: tb/pen_rate_sched_tb.sv
module pen_rate_sched_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        pen = 1'b0;
    logic        stb = 1'b0;
    logic        ok = 1'b0;
    logic [9:0]  sx = '0;
    logic [9:0]  sy = '0;
    logic [3:0]  ren;
    logic [39:0] rxlo, rxhi, rylo, ryhi;
    logic        req_o, acc_o, fast_o;
    logic [9:0]  acc_x, acc_y;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    // Regions: R0 100..200 x 100..200, R1 500..599 x 300..310,
    // R2 whole plane but disabled, R3 900..950 x 0..50
    assign ren  = 4'b1011;
    assign rxlo = {10'd900, 10'd0,    10'd500, 10'd100};
    assign rxhi = {10'd950, 10'd1023, 10'd599, 10'd200};
    assign rylo = {10'd0,   10'd0,    10'd300, 10'd100};
    assign ryhi = {10'd50,  10'd1023, 10'd310, 10'd200};

    pen_rate_sched u_dut (
        .clk(clk), .rst(rst), .tick_i(tick), .pen_down_i(pen),
        .smp_stb_i(stb), .smp_ok_i(ok), .smp_x_i(sx), .smp_y_i(sy),
        .rgn_en_i(ren), .rgn_xlo_i(rxlo), .rgn_xhi_i(rxhi),
        .rgn_ylo_i(rylo), .rgn_yhi_i(ryhi),
        .req_o(req_o), .acc_o(acc_o), .acc_x_o(acc_x), .acc_y_o(acc_y),
        .fast_o(fast_o)
    );

    // Vector: x[21:12] y[11:2] ok[1] expected-fast-after[0]
    localparam int NV = 10;
    localparam logic [21:0] VEC [NV] = '{
        {10'd150, 10'd150, 1'b1, 1'b1},  // R6 inside R0
        {10'd99,  10'd150, 1'b1, 1'b0},  // R6 just left of R0
        {10'd300, 10'd300, 1'b1, 1'b0},  // outside all
        {10'd200, 10'd200, 1'b1, 1'b1},  // R6 inclusive corner of R0
        {10'd600, 10'd305, 1'b0, 1'b0},  // R8 invalid, would be slow
        {10'd599, 10'd310, 1'b1, 1'b1},  // R6 corner of R1
        {10'd700, 10'd700, 1'b1, 1'b0},  // R7 only disabled R2 covers
        {10'd925, 10'd51,  1'b1, 1'b0},  // R6 one above R3
        {10'd900, 10'd0,   1'b1, 1'b1},  // R6 lower corner of R3
        {10'd50,  10'd50,  1'b0, 1'b0}   // R8 invalid, would be slow
    };

    task automatic check(input bit cond, input string rq, input int act, input int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic tick_once(output logic saw);
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        saw = req_o;
    endtask

    task automatic ticks_to_req(output int n);
        logic s;
        n = 0;
        for (int k = 0; k < 250; k++) begin
            tick_once(s);
            n++;
            if (s) break;
        end
        @(negedge clk);
        check(req_o == 1'b0, "R11", int'(req_o), 0);
    endtask

    task automatic send_sample(input logic [9:0] x, input logic [9:0] y, input logic good);
        @(negedge clk);
        stb = 1'b1; ok = good; sx = x; sy = y;
        @(negedge clk);
        stb = 1'b0; ok = 1'b0;
        if (good) begin
            check(acc_o == 1'b1, "R9", int'(acc_o), 1);
            check(acc_x == x && acc_y == y, "R9", int'(acc_x), int'(x));
        end else begin
            check(acc_o == 1'b0, "R8", int'(acc_o), 0);
        end
    endtask

    initial begin
        int  n;
        int  reqs;
        bit  exp_fast;
        logic s;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(req_o == 0 && acc_o == 0, "R1", int'(req_o | acc_o), 0);
        check(fast_o == 1, "R1", int'(fast_o), 1);

        // R2: pen up, no requests
        reqs = 0;
        for (int k = 0; k < 150; k++) begin
            tick_once(s);
            if (s) reqs++;
        end
        check(reqs == 0, "R2", reqs, 0);

        // R5: first request after pen-down on the 12th tick
        pen = 1'b1;
        ticks_to_req(n);
        check(n == 12, "R5", n, 12);
        check(fast_o == 1, "R5", int'(fast_o), 1);

        exp_fast = 1'b1;
        for (int v = 0; v < NV; v++) begin
            send_sample(VEC[v][21:12], VEC[v][11:2], VEC[v][1]);
            // R10: status holds until the period closes
            check(fast_o == exp_fast, "R10", int'(fast_o), int'(exp_fast));
            ticks_to_req(n);
            if (exp_fast) check(n == 12, "R3", n, 12);
            else          check(n == 100, "R4", n, 100);
            if (VEC[v][1]) exp_fast = VEC[v][0];
            check(fast_o == exp_fast, VEC[v][1] ? "R6" : "R8", int'(fast_o), int'(exp_fast));
        end

        // Go slow, then lift the pen mid-period
        send_sample(10'd700, 10'd700, 1'b1);
        ticks_to_req(n);
        check(fast_o == 0, "R7", int'(fast_o), 0);
        reqs = 0;
        for (int k = 0; k < 30; k++) begin
            tick_once(s);
            if (s) reqs++;
        end
        check(reqs == 0, "R4", reqs, 0);
        @(negedge clk) pen = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(fast_o == 1, "R2", int'(fast_o), 1);
        pen = 1'b1;
        ticks_to_req(n);
        check(n == 12, "R5", n, 12);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule